// File: doc/BRIEF.md
# Keyed Peripheral Power and Reset Gate

This block sits between a simple register port and one peripheral. It drives two signals into that peripheral: a power enable level and a reset pulse. Neither can be changed by a stray write. Each of the two writable registers accepts a write only when the top byte of the write data carries that register's own unlock key. A write that carries any other value in that byte is dropped without trace.

A status register holds a sticky flag. Hardware sets this flag whenever the peripheral is reset, whether by a system reset or by a keyed reset request. Software clears it only through a keyed write to the reset-control register. Software can therefore tell whether the peripheral lost its state since it last looked.

Register access is single-cycle. A write is taken on the clock edge where the write enable is high. Read data is a combinational function of the address and the current state. Any address the block does not own reads as zero.

Top module: `pwrrst_gate`

## Requirements
- R1: At byte offset 0x800 (power register), a write updates the power enable from write-data bit 0 only when write-data bits 31:24 equal 0x26. The new level appears on `pwr_en_o` after that clock edge.
- R2: At offset 0x804 (reset-control register), a write with bits 31:24 equal to 0xB1 and bit 0 set drives `periph_rst_o` high for exactly the one cycle after the write edge. Without another such write it is low in the next cycle.
- R3: The sticky flag reads at bit 16 of offset 0x814. It becomes 1 on the same edge that starts a reset pulse.
- R4: A write to 0x804 with key 0xB1 and bit 1 set, and bit 0 clear, clears the sticky flag. A keyed write with both bits 0 and 1 clear changes nothing.
- R5: When one keyed write to 0x804 sets both bit 0 and bit 1, the flag ends up set and a reset pulse is produced.
- R6: A write whose key byte does not match its register's key is discarded. This includes the other register's key. Power enable, sticky flag and reset output are all left unchanged.
- R7: While the system reset is asserted, `pwr_en_o` is 0, `periph_rst_o` is 0 and the sticky flag reads 1. This holds both at power-up and for a reset applied mid-run.
- R8: At 0x800, bit 0 reads back the enable, and the key byte and every other bit read 0. Offset 0x804 reads as 0. At 0x814 every bit except bit 16 reads 0. Any other address reads 0.
- R9: Writes to addresses other than 0x800 and 0x804 change no state, whatever key they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| reg_addr | input | 13 | Byte address of the register access |
| reg_wdata | input | 32 | Write data; bits 31:24 carry the unlock key |
| reg_we | input | 1 | Write strobe, taken on the rising clock edge |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pwr_en_o | output | 1 | Power enable to the peripheral |
| periph_rst_o | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
A wrong key comparison or a bad address decode shows up on `pwr_en_o`, or on the sticky bit read at 0x814, one cycle after the offending write. Both are sampled in the cycle after every write. The set-versus-clear priority matters only when both command bits arrive together. A bad priority is visible as a clear flag right after that combined write. A broken pulse shows as `periph_rst_o` missing, or still high, in the cycle after its write edge. A bad reset value shows on the ports as soon as reset is asserted.

// File: rtl/pwrrst_pkg.sv
package pwrrst_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned KEY_W      = 8;
  localparam int unsigned ADDR_W     = 13;
  localparam int unsigned STICKY_POS = 16;

  localparam logic [ADDR_W-1:0] OFF_POWER  = 13'h800;
  localparam logic [ADDR_W-1:0] OFF_RSTCTL = 13'h804;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 13'h814;

  localparam logic [KEY_W-1:0] KEY_POWER  = 8'h26;
  localparam logic [KEY_W-1:0] KEY_RSTCTL = 8'hB1;

  // command bit positions inside the reset-control register
  localparam int unsigned RC_GO_BIT  = 0;
  localparam int unsigned RC_CLR_BIT = 1;

  typedef enum logic [0:0] {
    SLOT_POWER  = 1'b0,
    SLOT_RSTCTL = 1'b1
  } key_slot_e;

  typedef struct packed {
    logic pwr_we;
    logic pwr_val;
    logic rst_we;
    logic rst_go;
    logic rst_clr;
  } keyed_cmd_t;
endpackage

// File: rtl/pwrrst_rst_sync.sv
module pwrrst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwrrst_decode.sv
module pwrrst_decode
  import pwrrst_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned DATA_BITS = REG_W,
  parameter int unsigned KEY_BITS  = KEY_W,
  parameter int unsigned NSLOT     = 2,
  parameter logic [NSLOT*ADDR_BITS-1:0] SLOT_OFFS = {OFF_RSTCTL, OFF_POWER},
  parameter logic [NSLOT*KEY_BITS-1:0]  SLOT_KEYS = {KEY_RSTCTL, KEY_POWER}
) (
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 we,
  output logic [NSLOT-1:0]     slot_hit
);
  localparam int unsigned KEY_LSB = DATA_BITS - KEY_BITS;

  logic [KEY_BITS-1:0] key_field;
  assign key_field = wdata[DATA_BITS-1:KEY_LSB];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic addr_match;
    logic key_match;
    assign addr_match  = (addr == SLOT_OFFS[s*ADDR_BITS +: ADDR_BITS]);
    assign key_match   = (key_field == SLOT_KEYS[s*KEY_BITS +: KEY_BITS]);
    assign slot_hit[s] = we & addr_match & key_match;
  end
endmodule

// File: rtl/pwrrst_power.sv
module pwrrst_power (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic upd_val,
  output logic en_q
);
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (upd_en) en_d = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (upd_en) en_q <= en_d;
  end
endmodule

// File: rtl/pwrrst_rstunit.sv
module pwrrst_rstunit (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we,
  input  logic cmd_go,
  input  logic cmd_clr,
  output logic pulse_q,
  output logic sticky_q
);
  logic pulse_d;
  logic sticky_d;
  logic fire;

  assign fire = cmd_we & cmd_go;

  always_comb begin
    pulse_d  = fire;
    sticky_d = sticky_q;
    if (fire)                  sticky_d = 1'b1;  // a new reset wins over a clear
    else if (cmd_we & cmd_clr) sticky_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      sticky_q <= 1'b1;
    end else begin
      pulse_q  <= pulse_d;
      sticky_q <= sticky_d;
    end
  end
endmodule

// File: rtl/pwrrst_rdmux.sv
module pwrrst_rdmux
  import pwrrst_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned DATA_BITS = REG_W,
  parameter int unsigned FLAG_POS  = STICKY_POS
) (
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 en,
  input  logic                 sticky,
  output logic [DATA_BITS-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_POWER:  rdata[0]        = en;
      OFF_STATUS: rdata[FLAG_POS] = sticky;
      default:    rdata           = '0;
    endcase
  end
endmodule

// File: rtl/pwrrst_gate.sv
module pwrrst_gate
  import pwrrst_pkg::*;
#(
  parameter int unsigned ADDR_BITS   = ADDR_W,
  parameter int unsigned DATA_BITS   = REG_W,
  parameter int unsigned KEY_BITS    = KEY_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_BITS-1:0] reg_addr,
  input  logic [DATA_BITS-1:0] reg_wdata,
  input  logic                 reg_we,
  output logic [DATA_BITS-1:0] reg_rdata,
  output logic                 pwr_en_o,
  output logic                 periph_rst_o
);
  localparam int unsigned NSLOT = 2;

  logic             rst_sync_n;
  logic [NSLOT-1:0] slot_hit;
  keyed_cmd_t       cmd;
  logic             sticky_q;

  pwrrst_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwrrst_decode #(
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS),
    .KEY_BITS  (KEY_BITS),
    .NSLOT     (NSLOT)
  ) u_dec (
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we),
    .slot_hit (slot_hit)
  );

  always_comb begin
    cmd.pwr_we  = slot_hit[SLOT_POWER];
    cmd.pwr_val = reg_wdata[0];
    cmd.rst_we  = slot_hit[SLOT_RSTCTL];
    cmd.rst_go  = reg_wdata[RC_GO_BIT];
    cmd.rst_clr = reg_wdata[RC_CLR_BIT];
  end

  pwrrst_power u_pwr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .upd_en  (cmd.pwr_we),
    .upd_val (cmd.pwr_val),
    .en_q    (pwr_en_o)
  );

  pwrrst_rstunit u_rst (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_we   (cmd.rst_we),
    .cmd_go   (cmd.rst_go),
    .cmd_clr  (cmd.rst_clr),
    .pulse_q  (periph_rst_o),
    .sticky_q (sticky_q)
  );

  pwrrst_rdmux #(
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS)
  ) u_rd (
    .addr   (reg_addr),
    .en     (pwr_en_o),
    .sticky (sticky_q),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/pwrrst_gate_chk.sv
module pwrrst_gate_chk
  import pwrrst_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] addr,
  input logic [31:0] wdata,
  input logic        we,
  input logic [31:0] rdata,
  input logic        pwr_en,
  input logic        periph_rst,
  input logic        sticky
);
  logic pwr_keyed;
  logic rc_keyed;
  logic pwr_badkey;
  assign pwr_keyed  = we && addr == OFF_POWER  && wdata[31:24] == KEY_POWER;
  assign rc_keyed   = we && addr == OFF_RSTCTL && wdata[31:24] == KEY_RSTCTL;
  assign pwr_badkey = we && addr == OFF_POWER  && wdata[31:24] != KEY_POWER;

  assert_pwr_keyed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_en) |-> $past(pwr_keyed));

  assert_pulse_keyed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> $past(rc_keyed && wdata[0]));

  assert_pulse_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> sticky);

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky) |-> $past(rc_keyed && wdata[1] && !wdata[0]));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rc_keyed && wdata[0] && wdata[1] |=> sticky && periph_rst);

  assert_bad_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_badkey |=> $stable(pwr_en));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~32'h0001_0001) == 32'h0);
endmodule

bind pwrrst_gate pwrrst_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .addr       (reg_addr),
  .wdata      (reg_wdata),
  .we         (reg_we),
  .rdata      (reg_rdata),
  .pwr_en     (pwr_en_o),
  .periph_rst (periph_rst_o),
  .sticky     (sticky_q)
);

// File: tb/pwrrst_gate_bench.sv
module pwrrst_gate_bench;
  logic        clk;
  logic        rst_n;
  logic [12:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic        pwr_en_o;
  logic        periph_rst_o;

  int checks;
  int errors;
  bit done;

  pwrrst_gate u_pwrrst_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_we       (reg_we),
    .reg_rdata    (reg_rdata),
    .pwr_en_o     (pwr_en_o),
    .periph_rst_o (periph_rst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: addr(13) wdata(32) exp{pwr,rst,sticky}(3) req(4)
  localparam int NV = 14;
  localparam logic [51:0] VEC [NV] = '{
    {13'h800, 32'h2600_0001, 3'b101, 4'd1},  // R1 keyed enable
    {13'h800, 32'h2500_0000, 3'b101, 4'd6},  // R6 bad key
    {13'h800, 32'h2600_0000, 3'b001, 4'd1},  // R1 keyed disable
    {13'h804, 32'hB100_0002, 3'b000, 4'd4},  // R4 clear flag
    {13'h804, 32'hB100_0000, 3'b000, 4'd4},  // R4 zero write no effect
    {13'h804, 32'hB000_0001, 3'b000, 4'd6},  // R6 bad key reset
    {13'h804, 32'hB100_0001, 3'b011, 4'd2},  // R2 pulse, R3 flag set
    {13'h804, 32'hB100_0002, 3'b000, 4'd4},  // R4 clear again
    {13'h804, 32'hB100_0003, 3'b011, 4'd5},  // R5 set wins
    {13'h800, 32'hB100_0001, 3'b001, 4'd6},  // R6 other key at power
    {13'h804, 32'h2600_0002, 3'b001, 4'd6},  // R6 other key at rstctl
    {13'h808, 32'hB100_0003, 3'b001, 4'd9},  // R9 foreign address
    {13'h814, 32'h2600_0001, 3'b001, 4'd9},  // R9 status not writable
    {13'h800, 32'h26FF_FFFF, 3'b101, 4'd1}   // R1 enable with noisy bits
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic read_chk(input string req, input logic [12:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    // R7 values while in reset
    check("R7 pwr in reset", {31'b0, pwr_en_o}, 32'd0);
    check("R7 rst in reset", {31'b0, periph_rst_o}, 32'd0);
    read_chk("R7 flag in reset", 13'h814, 32'h0001_0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      write_reg(v[51:39], v[38:7]);
      // one cycle after the write edge
      check({tag, " pwr"}, {31'b0, pwr_en_o}, {31'b0, v[6]});
      check({tag, " pulse"}, {31'b0, periph_rst_o}, {31'b0, v[5]});
      read_chk({tag, " flag"}, 13'h814, {15'b0, v[4], 16'b0});
    end

    // R2 pulse lasts one cycle only
    write_reg(13'h804, 32'hB100_0001);
    check("R2 pulse high", {31'b0, periph_rst_o}, 32'd1);
    @(negedge clk);
    check("R2 pulse gone", {31'b0, periph_rst_o}, 32'd0);

    // R8 readback
    read_chk("R8 power readback", 13'h800, 32'h0000_0001);
    read_chk("R8 rstctl reads zero", 13'h804, 32'h0);
    read_chk("R8 status", 13'h814, 32'h0001_0000);
    read_chk("R8 unowned addr", 13'h100, 32'h0);
    read_chk("R8 unowned addr2", 13'h808, 32'h0);

    // R7 mid-run reset after clearing the flag
    write_reg(13'h804, 32'hB100_0002);
    read_chk("R4 cleared before reset", 13'h814, 32'h0);
    #2 rst_n = 1'b0;
    #1;
    check("R7 pwr mid reset", {31'b0, pwr_en_o}, 32'd0);
    read_chk("R7 flag mid reset", 13'h814, 32'h0001_0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 pwr after reset", {31'b0, pwr_en_o}, 32'd0);
    check("R7 rst after reset", {31'b0, periph_rst_o}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule